// File: doc/BRIEF.md
# UART Interrupt and FIFO-Threshold Controller

This block is the status and interrupt section of a serial port. It watches the occupancy counts of the receive and transmit FIFOs, compares them with two programmable thresholds, and raises a receive-full condition and a transmit-empty condition. It also accepts a break-detect pulse from the line receiver and runs an idle timer that flags data left sitting in the receive FIFO.

Software sees six registers on a simple 32-bit read/write port: the FIFO counts, an interrupt enable mask, a write-one-to-clear register, a control register holding the timeout limit, a threshold register and a masked-status register. The single interrupt output is asserted whenever any enabled source is active. A masked status of zero tells a handler on a shared line that this port did not interrupt. The FIFO storage and the serial shifters sit outside; they reach this block only as counts and one-cycle pulses.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the threshold register reads 0x00004040, the control register reads 0x00003E00, the masked status reads 0 and irq is low.
- R2: A read at offset 0x0C returns the receive count in bits [7:0] and the transmit count in bits [15:8], upper bits zero.
- R3: Source bit 0 (receive-full) is active while rx_count is greater than or equal to the receive threshold, held in bits [6:0] of offset 0x20.
- R4: Source bit 1 (transmit-empty) is active while tx_count is less than or equal to the transmit threshold, held in bits [14:8] of offset 0x20; other bits of that register read zero.
- R5: Offset 0x2C returns the active sources ANDed with the enable register, with source bits 0, 1, 7 and 13; it reads zero when no enabled source is active.
- R6: A brk_pulse sets source bit 7, which stays set until a write to offset 0x14 with bit 7 set; writes there with bit 7 clear leave it unchanged.
- R7: Source bit 13 (receive timeout) sets when the receive FIFO has been non-empty for N consecutive cycles with no rx_push and no rx_pop, N being bits [15:8] of offset 0x1C; each push or pop restarts the count, an empty FIFO never fires, N of 0 disables it, and after a clear it does not set again until a new restart and a full N cycles.
- R8: Writing 0xFFFFFFFF to offset 0x14 clears both latched sources; the level sources 0 and 1 are unaffected by any clear write.
- R9: irq is high exactly when the masked status at 0x2C is non-zero.
- R10: Only bits 0, 1, 7 and 13 of the enable register at 0x10 are stored; the rest read zero.
- R11: When a latched source is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| rx_count | input | 8 | Receive FIFO occupancy |
| tx_count | input | 8 | Transmit FIFO occupancy |
| rx_push | input | 1 | One-cycle pulse per received character |
| rx_pop | input | 1 | One-cycle pulse per receive FIFO read |
| brk_pulse | input | 1 | One-cycle pulse on break detection |
| irq | output | 1 | Interrupt request |

## Verification
A wrong threshold compare or enable mask shows at the masked-status read and at irq in the same cycle the counts change, since both level sources are combinational from the inputs and registers. A timeout counter that restarts on the wrong events or stops one cycle early or late shows as bit 13 appearing one edge too soon or too late, so the bench samples the edge before and the edge of the expected firing. A latch that forgets its value or ignores a clear shows on the next read after the pulse or the clear write.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int THR_W  = 7,
  parameter int TOUT_W = 8,
  parameter logic [THR_W-1:0]  RX_THR_RST = 7'h40,
  parameter logic [THR_W-1:0]  TX_THR_RST = 7'h40,
  parameter logic [TOUT_W-1:0] TOUT_RST   = 8'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              brk_pulse,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_FIFO = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(8'h2C);
  localparam int B_RXF = 0;
  localparam int B_TXE = 1;
  localparam int B_BRK = 7;
  localparam int B_TO  = 13;
  localparam logic [31:0] SRC_MASK = (32'd1 << B_RXF) | (32'd1 << B_TXE) |
                                     (32'd1 << B_BRK) | (32'd1 << B_TO);
  localparam int TOUT_LSB = 8;
  localparam int TXT_LSB  = 8;

  logic [31:0]       en_q;
  logic [THR_W-1:0]  rx_thr, tx_thr;
  logic [TOUT_W-1:0] tout_thr, tcnt;
  logic              brk_q, to_q;
  logic              wr_en, wr_clr, wr_ctl, wr_thr;
  logic              restart, to_hit, rx_full, tx_empty;
  logic [31:0]       raw, masked;

  assign wr_en  = reg_we && reg_addr == A_EN;
  assign wr_clr = reg_we && reg_addr == A_CLR;
  assign wr_ctl = reg_we && reg_addr == A_CTL;
  assign wr_thr = reg_we && reg_addr == A_THR;

  assign rx_full  = {{(CNT_W > THR_W ? 0 : 1){1'b0}}, rx_count} >= CNT_W'(rx_thr);
  assign tx_empty = tx_count <= CNT_W'(tx_thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      rx_thr   <= RX_THR_RST;
      tx_thr   <= TX_THR_RST;
      tout_thr <= TOUT_RST;
    end else begin
      if (wr_en)  en_q <= reg_wdata & SRC_MASK;
      if (wr_ctl) tout_thr <= reg_wdata[TOUT_LSB +: TOUT_W];
      if (wr_thr) begin
        rx_thr <= reg_wdata[THR_W-1:0];
        tx_thr <= reg_wdata[TXT_LSB +: THR_W];
      end
    end
  end

  assign restart = rx_push || rx_pop || rx_count == '0;
  assign to_hit  = !restart && tout_thr != '0 &&
                   ({1'b0, tcnt} + 1'b1) == {1'b0, tout_thr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tcnt <= '0;
    else if (restart)          tcnt <= '0;
    else if (tcnt < tout_thr)  tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (brk_pulse)                     brk_q <= 1'b1;
      else if (wr_clr && reg_wdata[B_BRK]) brk_q <= 1'b0;
      if (to_hit)                        to_q <= 1'b1;
      else if (wr_clr && reg_wdata[B_TO])  to_q <= 1'b0;
    end
  end

  always_comb begin
    raw        = '0;
    raw[B_RXF] = rx_full;
    raw[B_TXE] = tx_empty;
    raw[B_BRK] = brk_q;
    raw[B_TO]  = to_q;
  end

  assign masked = raw & en_q;
  assign irq    = |masked;

  always_comb begin
    case (reg_addr)
      A_FIFO:  reg_rdata = 32'({tx_count, rx_count});
      A_EN:    reg_rdata = en_q;
      A_CTL:   reg_rdata = 32'(tout_thr) << TOUT_LSB;
      A_THR:   reg_rdata = (32'(tx_thr) << TXT_LSB) | 32'(rx_thr);
      A_MSK:   reg_rdata = masked;
      default: reg_rdata = '0;
    endcase
  end

  assert_en_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~SRC_MASK) == '0);

  assert_no_en_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  assert_brk_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> brk_q);

  assert_brk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !(wr_clr && reg_wdata[B_BRK])) |=> brk_q);

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push || rx_pop) |=> tcnt == '0);

  assert_empty_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0 && !to_q) |=> !to_q);

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata == 32'hFFFF_FFFF && !brk_pulse && !to_hit) |=> (!brk_q && !to_q));
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0]  rx_count = 0, tx_count = 0;
  logic        rx_push = 0, rx_pop = 0, brk_pulse = 0, irq;
  int errors = 0, checks = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  uart_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_count(rx_count), .tx_count(tx_count),
    .rx_push(rx_push), .rx_pop(rx_pop), .brk_pulse(brk_pulse), .irq(irq));

  // {rx_count, tx_count, enable[1:0], expected masked[1:0]} with thresholds at 64
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {8'd0,   8'd0,   2'b11, 2'b10},
    {8'd64,  8'd65,  2'b11, 2'b01},
    {8'd63,  8'd65,  2'b11, 2'b00},
    {8'd128, 8'd64,  2'b11, 2'b11},
    {8'd200, 8'd200, 2'b11, 2'b01},
    {8'd128, 8'd0,   2'b01, 2'b01},
    {8'd128, 8'd0,   2'b10, 2'b10},
    {8'd128, 8'd0,   2'b00, 2'b00},
    {8'd100, 8'd10,  2'b10, 2'b10}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic pulse_push();
    @(negedge clk); rx_push = 1; @(negedge clk); rx_push = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h10, d); chk("R1 enable", d, 32'h0);
    rd(8'h20, d); chk("R1 thresholds", d, 32'h4040);
    rd(8'h1C, d); chk("R1 control", d, 32'h3E00);
    rd(8'h2C, d); chk("R1 masked", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    // R2 FIFO counts
    rx_count = 8'h12; tx_count = 8'hA5;
    rd(8'h0C, d); chk("R2 fifo status", d, 32'h0000A512);
    // R10 enable storage
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R10 enable bits", d, 32'h2083);
    rd(8'h14, d); chk("R10 clear reads zero", d, 32'h0);
    wr(8'h10, 32'h0);
    // R3 R4 R5 R9 vector table
    for (int i = 0; i < NV; i++) begin
      rx_count = VEC[i][19:12]; tx_count = VEC[i][11:4];
      wr(8'h10, {30'd0, VEC[i][3:2]});
      rd(8'h2C, d); chk("R3/R4 R5 masked", d, {30'd0, VEC[i][1:0]});
      chk("R9 irq", {31'd0, irq}, {31'd0, |VEC[i][1:0]});
    end
    // R3 R4 programmed thresholds
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R4 threshold field widths", d, 32'h7F7F);
    wr(8'h20, 32'h0A05); rd(8'h20, d); chk("R4 threshold readback", d, 32'h0A05);
    wr(8'h10, 32'h3);
    rx_count = 5; tx_count = 11; rd(8'h2C, d); chk("R3 rx equal threshold", d, 32'h1);
    rx_count = 4; tx_count = 10; rd(8'h2C, d); chk("R4 tx equal threshold", d, 32'h2);
    // R6 break latch
    rx_count = 0; tx_count = 20;
    wr(8'h10, 32'h80); wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h2C, d); chk("R6 break idle", d, 32'h0);
    @(negedge clk); brk_pulse = 1; @(negedge clk); brk_pulse = 0;
    rd(8'h2C, d); chk("R6 break set", d, 32'h80);
    chk("R9 irq on break", {31'd0, irq}, 32'h1);
    wr(8'h14, 32'h2003); rd(8'h2C, d); chk("R6 other clear bits keep break", d, 32'h80);
    wr(8'h14, 32'h80); rd(8'h2C, d); chk("R6 break cleared", d, 32'h0);
    chk("R9 irq low", {31'd0, irq}, 32'h0);
    // R11 set beats clear
    @(negedge clk); brk_pulse = 1; reg_we = 1; reg_addr = 8'h14; reg_wdata = 32'h80;
    @(negedge clk); brk_pulse = 0; reg_we = 0;
    rd(8'h2C, d); chk("R11 set wins over clear", d, 32'h80);
    wr(8'h14, 32'h80);
    // R7 timeout
    rx_count = 3; wr(8'h1C, 32'h0500); wr(8'h10, 32'h2000); wr(8'h14, 32'hFFFF_FFFF);
    pulse_push();
    repeat (4) @(posedge clk); rd(8'h2C, d); chk("R7 not yet at N-1", d, 32'h0);
    @(posedge clk); rd(8'h2C, d); chk("R7 fires at N", d, 32'h2000);
    wr(8'h14, 32'h2000); repeat (10) @(posedge clk);
    rd(8'h2C, d); chk("R7 no refire after clear", d, 32'h0);
    pulse_push(); repeat (3) @(posedge clk);
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
    repeat (4) @(posedge clk); rd(8'h2C, d); chk("R7 pop restarts", d, 32'h0);
    @(posedge clk); rd(8'h2C, d); chk("R7 fires after pop restart", d, 32'h2000);
    wr(8'h14, 32'h2000);
    rx_count = 0; pulse_push(); repeat (20) @(posedge clk);
    rd(8'h2C, d); chk("R7 empty never fires", d, 32'h0);
    rx_count = 3; wr(8'h1C, 32'h0); pulse_push(); repeat (20) @(posedge clk);
    rd(8'h2C, d); chk("R7 zero limit disables", d, 32'h0);
    // R8 clear all
    wr(8'h1C, 32'h0500); wr(8'h20, 32'h4040);
    rx_count = 128; tx_count = 0; wr(8'h10, 32'h2083);
    pulse_push();
    @(negedge clk); brk_pulse = 1; @(negedge clk); brk_pulse = 0;
    repeat (8) @(posedge clk);
    rd(8'h2C, d); chk("R8 all sources set", d, 32'h2083);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h2C, d); chk("R8 clear all keeps levels", d, 32'h0003);
    chk("R9 irq from levels", {31'd0, irq}, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule